// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave (1K x 16)

This block is the logic side of a 1024-word by 16-bit serial EEPROM that a host drives over a three-wire bus. The bus has a select (`cs`), a bit clock (`sk`), a serial input (`di`) and a serial output whose driver can be switched off (`do_data` with `do_oe`). Each instruction is a start bit, an opcode and an address, followed by a data word for the two write-type instructions. The words are held in an internal register array. All bus pins are sampled with the system clock `clk`, and edges on them are found inside the block.

Besides single-word reads, the block performs sequential reads that step through the array and wrap around. It overwrites a word without a separate erase, and it erases or fills the whole array. Every change to the store starts a self-timed busy period of `WR_CYCLES` system clocks. A host that selects the block after such a change can poll ready/busy on the output pin and then release that pin.

Top module: `mw_eeprom`

## Requirements
- R1: On `sk` rising edges with `cs` high, `di` is shifted in MSB first. Zeros before the first 1 are ignored. That 1 is the start bit, and it is followed by a 2-bit opcode and a 10-bit address.
- R2: `do_oe` is 0 whenever `cs` is low, after reset, and while an instruction is being shifted in.
- R3: Opcode 2'b10 reads. Right after the last address bit, `do_oe` goes to 1 with `do_data` 0 (one dummy bit). Each following `sk` rising edge then presents the next bit of the addressed word, MSB first.
- R4: While `cs` stays high during a read, the word after the last one continues at the next address, with no dummy bit. The address after 1023 is 0.
- R5: Opcode 2'b01 followed by 16 data bits replaces the addressed word when `cs` falls. No erase is needed first.
- R6: Opcode 2'b11 sets the addressed word to 16'hFFFF. Opcode 2'b00 with address bits [9:8] = 2'b10 sets every word to 16'hFFFF. Opcode 2'b00 with [9:8] = 2'b01, followed by 16 data bits, writes those bits to every word.
- R7: Opcode 2'b00 with [9:8] = 2'b11 enables modifications and [9:8] = 2'b00 disables them, whatever the level of `pe`. Modifications are disabled after reset, and a disabled modification leaves the store unchanged.
- R8: A modification is carried out only if `pe` is 1 at the moment `cs` falls.
- R9: A modification keeps the block busy for `WR_CYCLES` clocks. The busy period begins in the clock where `cs` is seen low. While busy, start bits are ignored and the store is not written.
- R10: If `cs` is raised after a modification has started, `do_oe` is 1 and `do_data` shows 0 while busy and 1 when ready.
- R11: During such status display, a 1 shifted in on `di` turns `do_oe` off at the next `sk` falling edge. Until that edge, the output stays driven.
- R12: Dropping `cs` before an instruction is complete cancels it. The store is not changed, and the next selection waits for a new start bit.
- R13: After reset, every word reads 16'hFFFF and the block is not busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs | input | 1 | Bus select, active high |
| sk | input | 1 | Bus bit clock |
| di | input | 1 | Serial command, address and data input |
| pe | input | 1 | Program enable for modifications |
| do_data | output | 1 | Serial output value |
| do_oe | output | 1 | Serial output driver enable |

## Verification
Some properties are checked on every cycle. The output driver is never on one clock after a deselect. Read data changes only after an `sk` rising edge. The first bit driven by a read is zero. A store write always starts the busy timer, never lands while the timer runs, and begins only with `cs` low. The bench scenarios cover the word contents after each instruction: enable and `pe` gating, sequential wrap from 1023 to 0, aborts, and whole-array fills. They also cover the length of the busy window and the release of the status output.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [1:0] {
        OPC_EXT   = 2'b00,
        OPC_WRITE = 2'b01,
        OPC_READ  = 2'b10,
        OPC_ERASE = 2'b11
    } opc_e;

    typedef enum logic [1:0] {
        EXT_LOCK   = 2'b00,
        EXT_FILL   = 2'b01,
        EXT_WIPE   = 2'b10,
        EXT_UNLOCK = 2'b11
    } ext_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CMD,
        S_DATA,
        S_READ,
        S_DONE,
        S_STAT
    } state_e;

    typedef enum logic [2:0] {
        PEND_NONE,
        PEND_WORD,
        PEND_CLEAR,
        PEND_FILL,
        PEND_WIPE
    } pend_e;

    // Store operation requested by a pending modification
    typedef struct packed {
        logic one;
        logic all;
        logic ones;
    } wop_t;

    function automatic pend_e pend_of(opc_e o, ext_e e);
        pend_e p;
        case (o)
            OPC_WRITE: p = PEND_WORD;
            OPC_ERASE: p = PEND_CLEAR;
            OPC_EXT:   p = (e == EXT_FILL) ? PEND_FILL :
                           (e == EXT_WIPE) ? PEND_WIPE : PEND_NONE;
            default:   p = PEND_NONE;
        endcase
        return p;
    endfunction

    function automatic logic takes_data(pend_e p);
        return (p == PEND_WORD) || (p == PEND_FILL);
    endfunction

    function automatic wop_t wop_of(pend_e p);
        wop_t w;
        w.one  = (p == PEND_WORD) || (p == PEND_CLEAR);
        w.all  = (p == PEND_FILL) || (p == PEND_WIPE);
        w.ones = (p == PEND_CLEAR) || (p == PEND_WIPE);
        return w;
    endfunction

endpackage

// File: rtl/mw_edge_det.sv
module mw_edge_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] sig,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev_q;

    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst) prev_q[i] <= 1'b0;
                else     prev_q[i] <= sig[i];
            end
            assign rise[i] = sig[i] & ~prev_q[i];
            assign fall[i] = ~sig[i] & prev_q[i];
        end
    endgenerate
endmodule

// File: rtl/mw_busy_timer.sv
module mw_busy_timer #(
    parameter int CYCLES = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (start)         cnt_q <= CNT_W'(CYCLES);
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/mw_store.sv
module mw_store #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_one,
    input  logic              we_all,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (we_all) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= wdata;
        end else if (we_one) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
    import mw_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 16,
    parameter int WR_CYCLES = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic cs,
    input  logic sk,
    input  logic di,
    input  logic pe,
    output logic do_data,
    output logic do_oe
);
    localparam int CMD_W = 2 + ADDR_W;
    localparam int MAXB  = (CMD_W > DATA_W) ? CMD_W : DATA_W;
    localparam int CNT_W = $clog2(MAXB);
    localparam int BIT_W = $clog2(DATA_W);

    // Pin edge detection: index 1 is cs, index 0 is sk
    logic [1:0] rise, fall;
    logic cs_rise, cs_fall, sk_rise, sk_fall;

    mw_edge_det #(.N(2)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .sig  ({cs, sk}),
        .rise (rise),
        .fall (fall)
    );

    assign cs_rise = rise[1];
    assign cs_fall = fall[1];
    assign sk_rise = rise[0];
    assign sk_fall = fall[0];

    state_e            state;
    logic [CMD_W-2:0]  cmd_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] data_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BIT_W-1:0]  bit_q;
    pend_e             pend_q;
    logic wen_q, oe_q, dout_q, stat_q, flag_q, rel_q;

    logic [CMD_W-1:0]  cmd_nxt;
    logic [DATA_W-1:0] data_nxt;
    opc_e              opc;
    ext_e              ext;
    pend_e             pend_new;
    logic              busy, fire, we_one, we_all;
    wop_t              wop;
    logic [DATA_W-1:0] wdata, rd_word;

    assign cmd_nxt  = {cmd_q, di};
    assign data_nxt = {data_q[DATA_W-2:0], di};
    assign opc      = opc_e'(cmd_nxt[CMD_W-1 -: 2]);
    assign ext      = ext_e'(cmd_nxt[ADDR_W-1 -: 2]);
    assign pend_new = pend_of(opc, ext);

    // A complete modification is committed at the deselect edge
    assign fire   = cs_fall && (state == S_DONE) && (pend_q != PEND_NONE)
                    && wen_q && pe && !busy;
    assign wop    = wop_of(pend_q);
    assign we_one = fire && wop.one;
    assign we_all = fire && wop.all;
    assign wdata  = wop.ones ? '1 : data_q;

    mw_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk    (clk),
        .rst    (rst),
        .we_one (we_one),
        .we_all (we_all),
        .waddr  (addr_q),
        .wdata  (wdata),
        .raddr  (addr_q),
        .rdata  (rd_word)
    );

    mw_busy_timer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (fire),
        .busy  (busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            cmd_q  <= '0;
            cnt_q  <= '0;
            data_q <= '0;
            addr_q <= '0;
            bit_q  <= '0;
            pend_q <= PEND_NONE;
            wen_q  <= 1'b0;
            oe_q   <= 1'b0;
            dout_q <= 1'b0;
            stat_q <= 1'b0;
            flag_q <= 1'b0;
            rel_q  <= 1'b0;
        end else if (cs_fall) begin
            state  <= S_IDLE;
            oe_q   <= 1'b0;
            stat_q <= 1'b0;
            rel_q  <= 1'b0;
            pend_q <= PEND_NONE;
            if (fire) flag_q <= 1'b1;
        end else if (cs_rise) begin
            rel_q <= 1'b0;
            if (flag_q) begin
                state  <= S_STAT;
                oe_q   <= 1'b1;
                stat_q <= 1'b1;
            end else begin
                state <= S_IDLE;
            end
        end else if (cs) begin
            case (state)
                S_IDLE: begin
                    if (sk_rise && di && !busy) begin
                        state <= S_CMD;
                        cnt_q <= '0;
                    end
                end
                S_CMD: begin
                    if (sk_rise) begin
                        cmd_q <= cmd_nxt[CMD_W-2:0];
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == CNT_W'(CMD_W - 1)) begin
                            cnt_q  <= '0;
                            addr_q <= cmd_nxt[ADDR_W-1:0];
                            pend_q <= pend_new;
                            if (opc == OPC_READ) begin
                                bit_q  <= '0;
                                oe_q   <= 1'b1;
                                dout_q <= 1'b0;
                                state  <= S_READ;
                            end else if (takes_data(pend_new)) begin
                                state <= S_DATA;
                            end else begin
                                state <= S_DONE;
                                if (opc == OPC_EXT && ext == EXT_UNLOCK) wen_q <= 1'b1;
                                if (opc == OPC_EXT && ext == EXT_LOCK)   wen_q <= 1'b0;
                            end
                        end
                    end
                end
                S_DATA: begin
                    if (sk_rise) begin
                        data_q <= data_nxt;
                        cnt_q  <= cnt_q + 1'b1;
                        if (cnt_q == CNT_W'(DATA_W - 1)) begin
                            cnt_q <= '0;
                            state <= S_DONE;
                        end
                    end
                end
                S_READ: begin
                    if (sk_rise) begin
                        dout_q <= rd_word[BIT_W'(DATA_W - 1) - bit_q];
                        if (bit_q == BIT_W'(DATA_W - 1)) begin
                            bit_q  <= '0;
                            addr_q <= addr_q + 1'b1;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                        end
                    end
                end
                S_STAT: begin
                    if (sk_rise && di) rel_q <= 1'b1;
                    if (sk_fall && rel_q) begin
                        rel_q  <= 1'b0;
                        oe_q   <= 1'b0;
                        stat_q <= 1'b0;
                        flag_q <= 1'b0;
                        state  <= S_IDLE;
                    end
                end
                default: ;
            endcase
        end
    end

    assign do_oe   = oe_q;
    assign do_data = oe_q & (stat_q ? ~busy : dout_q);

endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk (
    input logic clk,
    input logic rst,
    input logic cs,
    input logic sk,
    input logic do_oe,
    input logic do_data,
    input logic stat_q,
    input logic busy,
    input logic we_one,
    input logic we_all
);
    // R2: driver is off one clock after cs is seen low
    a_r2_off_when_deselected: assert property (@(posedge clk) disable iff (rst)
        !cs |=> !do_oe);

    // R3: first driven bit of a read is the dummy zero
    a_r3_dummy_zero: assert property (@(posedge clk) disable iff (rst)
        ($rose(do_oe) && !stat_q) |-> !do_data);

    // R3: read data moves only after an sk rising edge
    a_r3_moves_on_sk_rise: assert property (@(posedge clk) disable iff (rst)
        (do_oe && $past(do_oe) && !stat_q && !$past(stat_q)
         && (do_data != $past(do_data))) |-> ($past(sk) && !$past(sk, 2)));

    // R9: busy period begins only from a deselect
    a_r9_busy_from_deselect: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !$past(cs));

    // R9: no store write while the timer runs
    a_r9_no_write_busy: assert property (@(posedge clk) disable iff (rst)
        (we_one || we_all) |-> !busy);

    // R5: every store write is followed by a busy period
    a_r5_write_starts_timer: assert property (@(posedge clk) disable iff (rst)
        (we_one || we_all) |=> busy);
endmodule

bind mw_eeprom mw_eeprom_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .cs      (cs),
    .sk      (sk),
    .do_oe   (do_oe),
    .do_data (do_data),
    .stat_q  (stat_q),
    .busy    (busy),
    .we_one  (we_one),
    .we_all  (we_all)
);

// File: tb/sim_mw_eeprom.sv
module sim_mw_eeprom;
    localparam int AW    = 10;
    localparam int DW    = 16;
    localparam int WRC   = 200;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0, pe = 1'b1;
    logic do_data, do_oe;

    always #4 clk = ~clk;

    mw_eeprom #(.ADDR_W(AW), .DATA_W(DW), .WR_CYCLES(WRC)) u0 (
        .clk (clk), .rst (rst), .cs (cs), .sk (sk), .di (di), .pe (pe),
        .do_data (do_data), .do_oe (do_oe)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [DW-1:0] model [DEPTH];
    logic en_m = 1'b0;
    logic mid_oe, mid_do;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sbit(input logic b);
        di = b; sk = 1'b1; tick(3);
        mid_oe = do_oe; mid_do = do_data;
        sk = 1'b0; tick(3);
    endtask

    task automatic cs_hi();
        cs = 1'b1; tick(3);
    endtask

    task automatic cs_lo();
        cs = 1'b0; di = 1'b0; sk = 1'b0; tick(3);
    endtask

    task automatic send_hdr(input logic [1:0] op, input logic [AW-1:0] a);
        sbit(1'b1);
        for (int i = 1; i >= 0; i--) sbit(op[i]);
        for (int i = AW - 1; i >= 0; i--) sbit(a[i]);
    endtask

    task automatic send_data(input logic [DW-1:0] d);
        for (int i = DW - 1; i >= 0; i--) sbit(d[i]);
    endtask

    // Modification or enable/disable instruction with status handling
    task automatic mod_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
        logic [1:0] ex;
        bit is_mod, with_data, exec;
        int k;
        ex = a[AW-1 -: 2];
        is_mod    = (op != 2'b00) || (ex == 2'b01) || (ex == 2'b10);
        with_data = (op == 2'b01) || (op == 2'b00 && ex == 2'b01);
        exec      = is_mod && en_m && pe;
        cs_hi();
        send_hdr(op, a);
        if (with_data) send_data(d);
        cs_lo();
        if (exec) begin
            if (op == 2'b01) model[a] = d;
            else if (op == 2'b11) model[a] = '1;
            else for (int i = 0; i < DEPTH; i++) model[i] = (ex == 2'b01) ? d : '1;
        end
        if (op == 2'b00 && ex == 2'b11) en_m = 1'b1;
        if (op == 2'b00 && ex == 2'b00) en_m = 1'b0;
        cs_hi();
        if (exec) begin
            check(do_oe && !do_data, {req, " R10 busy shown"}, {do_oe, do_data}, 2'b10);
            k = 0;
            while (do_data !== 1'b1 && k < 3 * WRC) begin tick(1); k++; end
            check(do_data === 1'b1, {req, " R10 ready shown"}, do_data, 1);
            check(k >= WRC - 12 && k <= WRC, "R9 busy length", k, WRC - 6);
            sbit(1'b1);
            check(mid_oe === 1'b1, "R11 driven before sk fall", mid_oe, 1);
            check(do_oe === 1'b0, "R11 released on sk fall", do_oe, 0);
        end else begin
            check(do_oe === 1'b0, {req, " no modification started"}, do_oe, 0);
        end
        cs_lo();
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input int nw, input int lead, input string req);
        logic [DW-1:0] w;
        logic [AW-1:0] ea;
        cs_hi();
        for (int i = 0; i < lead; i++) sbit(1'b0);
        check(do_oe === 1'b0, "R2 off while shifting", do_oe, 0);
        send_hdr(2'b10, a);
        check(do_oe === 1'b1 && do_data === 1'b0, "R3 dummy zero", {do_oe, do_data}, 2'b10);
        for (int n = 0; n < nw; n++) begin
            w = '0;
            for (int b = 0; b < DW; b++) begin
                sbit(1'b0);
                w = {w[DW-2:0], do_data};
            end
            ea = a + AW'(n);
            check(w === model[ea], req, w, model[ea]);
        end
        cs_lo();
        check(do_oe === 1'b0, "R2 off after deselect", do_oe, 0);
    endtask

    initial begin
        tick(1000000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < DEPTH; i++) model[i] = '1;
        tick(5);
        rst = 1'b0;
        tick(2);
        check(do_oe === 1'b0, "R13 reset output off", do_oe, 0);
        rd_chk(10'd5, 1, 0, "R13 erased after reset");

        // R7: disabled after reset
        mod_op(2'b01, 10'd5, 16'h1234, "R7 write while disabled");
        rd_chk(10'd5, 1, 0, "R7 store unchanged");

        // R7: enable ignores pe
        pe = 1'b0;
        mod_op(2'b00, 10'h300, '0, "R7 enable");
        pe = 1'b1;
        mod_op(2'b01, 10'd5, 16'hA5C3, "R5 write");
        rd_chk(10'd5, 1, 0, "R5 written word");
        mod_op(2'b01, 10'd5, 16'h0F0F, "R5 overwrite");
        rd_chk(10'd5, 1, 0, "R5 overwritten word");

        // R8: pe low at deselect
        pe = 1'b0;
        mod_op(2'b01, 10'd5, 16'h7777, "R8 pe low");
        pe = 1'b1;
        rd_chk(10'd5, 1, 0, "R8 store unchanged");

        mod_op(2'b11, 10'd5, '0, "R6 erase word");
        rd_chk(10'd5, 1, 0, "R6 erased word");

        // R4: sequential read across the wrap
        mod_op(2'b01, 10'd1023, 16'hBEEF, "R5 last word");
        mod_op(2'b01, 10'd0, 16'h1357, "R5 first word");
        rd_chk(10'd1022, 4, 0, "R4 sequential wrap");

        // R1: leading zeros before the start bit
        rd_chk(10'd1023, 1, 3, "R1 leading zeros");

        // R12: abort mid-instruction
        cs_hi();
        sbit(1'b1); sbit(1'b0); sbit(1'b1);
        for (int i = AW - 1; i >= 0; i--) sbit(1'b0 ^ (i == 2));
        for (int i = 0; i < 8; i++) sbit(1'b1);
        cs_lo();
        cs_hi();
        check(do_oe === 1'b0, "R12 aborted, no status", do_oe, 0);
        cs_lo();
        rd_chk(10'd4, 1, 0, "R12 store unchanged");

        // R9: start bits ignored while busy
        cs_hi(); send_hdr(2'b01, 10'd9); send_data(16'h4242); cs_lo();
        model[9] = 16'h4242;
        cs_hi();
        sbit(1'b1);
        check(do_oe === 1'b0, "R11 released during busy", do_oe, 0);
        send_hdr(2'b10, 10'd9);
        check(do_oe === 1'b0, "R9 read ignored while busy", do_oe, 0);
        cs_lo();
        tick(WRC);
        rd_chk(10'd9, 1, 0, "R9 word after busy");

        // R6: whole-array fill and wipe
        mod_op(2'b00, 10'h100, 16'h6C6C, "R6 fill all");
        rd_chk(10'd0, 1, 0, "R6 filled low");
        rd_chk(10'd777, 2, 0, "R6 filled mid");
        mod_op(2'b00, 10'h200, '0, "R6 wipe all");
        rd_chk(10'd1023, 2, 0, "R6 wiped");

        // R7: disable then ignored
        mod_op(2'b00, 10'h000, '0, "R7 disable");
        mod_op(2'b01, 10'd3, 16'h0001, "R7 write after disable");
        rd_chk(10'd3, 1, 0, "R7 store unchanged");

        // Random mix
        for (int it = 0; it < 30; it++) begin
            int r;
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            r  = $urandom % 5;
            a  = AW'($urandom);
            d  = DW'($urandom);
            pe = ($urandom % 4) != 0;
            case (r)
                0, 1: mod_op(2'b01, a, d, "R5 random write");
                2:    mod_op(2'b11, a, d, "R6 random erase");
                3:    rd_chk(a, 2, $urandom % 3, "R3 random read");
                default: mod_op(2'b00, (($urandom % 4) != 0) ? 10'h300 : 10'h000, d, "R7 random enable");
            endcase
        end
        pe = 1'b1;
        rd_chk(10'd1020, 6, 0, "R4 final wrap read");

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule